// File: doc/BRIEF.md
# Sliding-Window Spike Feature Buffer

This block sits between two spiking convolution layers. It collects the output spikes of the previous layer, one feature-map column at a time, and serves 3x3 convolution windows to the neuron cores of its own layer. Spikes arrive as bytes on a valid/ready stream. A column register (stage one) gathers a whole column. That column then moves in one cycle into a bank of window FIFOs (stage two). There is one FIFO for each vertical window position, and each FIFO keeps its three-row slice of the three most recent columns.

A kernel operation starts only when the FIFOs hold three columns and the next layer reports that its own column register is empty. The block then streams the window spikes onto the core bus one byte per cycle and waits for a completion pulse from the cores. On that pulse it drops the oldest column, which moves the window one column along the rows. When both stages are full, the byte stream is stalled. Because each layer's empty flag gates the start of the layer before it, a stall spreads back toward the input layer.

Top module: `spk_feature_buf`

## Requirements
- R1: After reset, `up_ready` and `col_empty` are 1, and `core_valid` and `k_start` are 0.
- R2: Stage one stores incoming bytes of a column in row-major order. Byte b of row r (b counts 0..CH_BYTES-1) lands at column byte r*CH_BYTES+b. `col_empty` is low whenever stage one holds any byte.
- R3: A complete column moves to stage two only when stage two holds fewer than three columns. While stage one holds a complete column, `up_ready` is 0, so upstream bytes stall.
- R4: `k_start` is a one-cycle pulse. It is raised only when stage two holds three columns and `nxt_empty` was 1 at the previous clock edge. The first window beat appears on the core bus in the cycle after `k_start`.
- R5: A kernel operation emits 9*CH_BYTES beats for each vertical position v, with v running 0..ROWS-3. Within a position, the order is window row r, then window column c, then channel byte b, with b changing fastest and c=0 being the oldest column. Each beat carries byte (v+r)*CH_BYTES+b of column c.
- R6: `core_vpos` equals v on every beat, and `core_wlast` is 1 only on the final beat of each vertical position.
- R7: A `k_done` pulse received after the last beat drops the oldest column, so the next operation uses columns k+1..k+3. A `k_done` that arrives while beats are still streaming is ignored.
- R8: Until the `k_done` that releases a window, no new column enters stage two. With a column waiting in stage one, `up_ready` stays 0 throughout the stream and the wait for `k_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream spike byte valid |
| up_data | input | 8 | Upstream spike byte (8 channels) |
| up_ready | output | 1 | Stage one can accept a byte |
| col_empty | output | 1 | Stage one holds no byte (feeds previous layer's `nxt_empty`) |
| nxt_empty | input | 1 | Next layer's column stage is empty |
| k_start | output | 1 | Kernel operation start pulse |
| k_done | input | 1 | Kernel operation completion pulse from the cores |
| core_valid | output | 1 | Core bus beat valid |
| core_data | output | 8 | Eight window spikes |
| core_vpos | output | VPW | Vertical window position of the beat |
| core_wlast | output | 1 | Last beat of a vertical position |

## Verification
The hardest state to reach is a full pipeline: stage two holds a window that is in use while stage one already holds the next column, so the next column must wait. The bench gets there by holding `nxt_empty` low while it pushes four whole columns, and then confirms that the stream stalls. It then releases the start and checks that `up_ready` stays low through the stream and the wait for `k_done`. Completion pulses are also injected in the middle of a stream, which shows they are ignored: a wrongly accepted pulse would shift every later window by an extra column.

// File: rtl/spk_fb_pkg.sv
package spk_fb_pkg;

    localparam int KWIN = 3;

    typedef enum logic [1:0] {
        FB_IDLE   = 2'd0,
        FB_STREAM = 2'd1,
        FB_WAIT   = 2'd2
    } fb_state_e;

    typedef struct packed {
        logic [7:0] vpos;
        logic [1:0] row;
        logic [1:0] col;
        logic [7:0] chb;
    } fb_beat_t;

    function automatic logic [1:0] slot_add(input logic [1:0] base, input logic [1:0] off);
        logic [2:0] s;
        s = {1'b0, base} + {1'b0, off};
        if (s >= 3'(KWIN)) s = s - 3'(KWIN);
        return s[1:0];
    endfunction

endpackage

// File: rtl/spk_fb_col_stage.sv
module spk_fb_col_stage #(
    parameter int ROWS     = 5,
    parameter int CH_BYTES = 2,
    localparam int COLB    = ROWS * CH_BYTES,
    localparam int CW      = $clog2(COLB + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    input  logic [7:0]        up_data,
    output logic              up_ready,
    output logic              col_empty,
    output logic              col_full,
    output logic [COLB*8-1:0] col_data,
    input  logic              xfer
);

    logic [CW-1:0]     fill_q;
    logic [COLB*8-1:0] bytes_q;
    logic              take;

    assign col_full  = (fill_q == CW'(COLB));
    assign up_ready  = !col_full;
    assign col_empty = (fill_q == '0);
    assign take      = up_valid && !col_full;
    assign col_data  = bytes_q;

    always_ff @(posedge clk) begin
        if (rst)       fill_q <= '0;
        else if (xfer) fill_q <= '0;
        else if (take) fill_q <= fill_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (take) bytes_q[int'(fill_q)*8 +: 8] <= up_data;
    end

    // R3
    xfer_full_chk: assert property (@(posedge clk) disable iff (rst) xfer |-> col_full)
        else $error("column handed over before complete");

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst) fill_q <= CW'(COLB))
        else $error("column fill count out of range");

endmodule

// File: rtl/spk_fb_win_fifo.sv
module spk_fb_win_fifo #(
    parameter int CH_BYTES = 2,
    localparam int SLICE   = 3 * CH_BYTES
) (
    input  logic               clk,
    input  logic               push,
    input  logic [1:0]         wr_slot,
    input  logic [SLICE*8-1:0] wdata,
    input  logic [1:0]         rd_slot,
    input  logic [1:0]         rd_row,
    input  logic [7:0]         rd_chb,
    output logic [7:0]         rd_byte
);

    logic [SLICE*8-1:0] mem_q [0:2];

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_slot] <= wdata;
    end

    always_comb begin
        int idx;
        idx     = (int'(rd_row) * CH_BYTES + int'(rd_chb)) * 8;
        rd_byte = mem_q[rd_slot][idx +: 8];
    end

endmodule

// File: rtl/spk_fb_ctrl.sv
module spk_fb_ctrl
    import spk_fb_pkg::*;
#(
    parameter int NVP      = 3,
    parameter int CH_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       col_full,
    input  logic       nxt_empty,
    input  logic       k_done,
    output logic       xfer,
    output logic [1:0] win_cnt,
    output logic [1:0] wr_slot,
    output logic [1:0] rd_base,
    output logic       k_start,
    output logic       bt_valid,
    output fb_beat_t   bt,
    output logic       bt_wlast
);

    fb_state_e state_q;
    logic      pop, go, b_end, c_end, r_end, v_end;

    assign xfer     = col_full && (win_cnt < 2'd3);
    assign pop      = (state_q == FB_WAIT) && k_done;
    assign go       = (state_q == FB_IDLE) && (win_cnt == 2'd3) && nxt_empty;
    assign bt_valid = (state_q == FB_STREAM);

    assign b_end    = (bt.chb == 8'(CH_BYTES - 1));
    assign c_end    = (bt.col == 2'd2);
    assign r_end    = (bt.row == 2'd2);
    assign v_end    = (bt.vpos == 8'(NVP - 1));
    assign bt_wlast = b_end && c_end && r_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            wr_slot <= '0;
            rd_base <= '0;
        end else begin
            if (xfer) wr_slot <= slot_add(wr_slot, 2'd1);
            if (pop)  rd_base <= slot_add(rd_base, 2'd1);
            if (xfer && !pop)      win_cnt <= win_cnt + 2'd1;
            else if (pop && !xfer) win_cnt <= win_cnt - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FB_IDLE;
            k_start <= 1'b0;
            bt      <= '0;
        end else begin
            k_start <= go;
            case (state_q)
                FB_IDLE: begin
                    if (go) begin
                        state_q <= FB_STREAM;
                        bt      <= '0;
                    end
                end
                FB_STREAM: begin
                    if (!b_end) begin
                        bt.chb <= bt.chb + 8'd1;
                    end else begin
                        bt.chb <= '0;
                        if (!c_end) begin
                            bt.col <= bt.col + 2'd1;
                        end else begin
                            bt.col <= '0;
                            if (!r_end) begin
                                bt.row <= bt.row + 2'd1;
                            end else begin
                                bt.row <= '0;
                                if (v_end) state_q <= FB_WAIT;
                                else       bt.vpos <= bt.vpos + 8'd1;
                            end
                        end
                    end
                end
                FB_WAIT: begin
                    if (k_done) state_q <= FB_IDLE;
                end
                default: state_q <= FB_IDLE;
            endcase
        end
    end

    // R7
    pop_full_chk: assert property (@(posedge clk) disable iff (rst) pop |-> (win_cnt == 2'd3))
        else $error("column dropped from a partial window");

    // R8
    no_push_in_use_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != FB_IDLE) |-> !xfer)
        else $error("column entered stage two while window in use");

endmodule

// File: rtl/spk_feature_buf.sv
module spk_feature_buf
    import spk_fb_pkg::*;
#(
    parameter int ROWS     = 5,
    parameter int CH_BYTES = 2,
    localparam int NVP     = ROWS - 2,
    localparam int VPW     = (NVP > 1) ? $clog2(NVP) : 1,
    localparam int COLB    = ROWS * CH_BYTES,
    localparam int SLICE   = 3 * CH_BYTES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           up_valid,
    input  logic [7:0]     up_data,
    output logic           up_ready,
    output logic           col_empty,
    input  logic           nxt_empty,
    output logic           k_start,
    input  logic           k_done,
    output logic           core_valid,
    output logic [7:0]     core_data,
    output logic [VPW-1:0] core_vpos,
    output logic           core_wlast
);

    logic              col_full, xfer, bt_valid, bt_wlast;
    logic [COLB*8-1:0] col_data;
    logic [1:0]        win_cnt, wr_slot, rd_base, rd_slot;
    fb_beat_t          bt;
    logic [7:0]        vp_byte [NVP];

    spk_fb_col_stage #(.ROWS(ROWS), .CH_BYTES(CH_BYTES)) u_col (
        .clk(clk), .rst(rst), .up_valid(up_valid), .up_data(up_data),
        .up_ready(up_ready), .col_empty(col_empty), .col_full(col_full),
        .col_data(col_data), .xfer(xfer)
    );

    spk_fb_ctrl #(.NVP(NVP), .CH_BYTES(CH_BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .col_full(col_full), .nxt_empty(nxt_empty),
        .k_done(k_done), .xfer(xfer), .win_cnt(win_cnt), .wr_slot(wr_slot),
        .rd_base(rd_base), .k_start(k_start), .bt_valid(bt_valid), .bt(bt),
        .bt_wlast(bt_wlast)
    );

    assign rd_slot = slot_add(rd_base, bt.col);

    for (genvar v = 0; v < NVP; v++) begin : g_vp
        spk_fb_win_fifo #(.CH_BYTES(CH_BYTES)) u_fifo (
            .clk(clk), .push(xfer), .wr_slot(wr_slot),
            .wdata(col_data[v*CH_BYTES*8 +: SLICE*8]),
            .rd_slot(rd_slot), .rd_row(bt.row), .rd_chb(bt.chb),
            .rd_byte(vp_byte[v])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_valid <= 1'b0;
            core_data  <= '0;
            core_vpos  <= '0;
            core_wlast <= 1'b0;
        end else begin
            core_valid <= bt_valid;
            core_data  <= vp_byte[VPW'(bt.vpos)];
            core_vpos  <= VPW'(bt.vpos);
            core_wlast <= bt_valid && bt_wlast;
        end
    end

    // R4
    start_beat_chk: assert property (@(posedge clk) disable iff (rst) k_start |=> core_valid)
        else $error("no beat after start");

    // R4
    start_gate_chk: assert property (@(posedge clk) disable iff (rst) $rose(k_start) |-> $past(nxt_empty))
        else $error("start while next layer busy");

    // R6
    wlast_valid_chk: assert property (@(posedge clk) disable iff (rst) core_wlast |-> core_valid)
        else $error("window last without beat");

endmodule

// File: tb/test_spk_feature_buf.sv
module test_spk_feature_buf;

    localparam int ROWS = 5;
    localparam int CHB  = 2;
    localparam int NVP  = ROWS - 2;
    localparam int VPW  = 2;
    localparam int BPV  = 9 * CHB;
    localparam int BPC  = NVP * BPV;

    // case table: columns, byte gap, cycles nxt_empty held low, done delay, early done
    localparam int NCASE = 4;
    localparam int TBL [NCASE][5] = '{
        '{3, 0,  0, 0, 0},
        '{5, 1,  6, 2, 1},
        '{4, 3,  0, 5, 0},
        '{6, 0, 45, 0, 1}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic up_valid = 1'b0, nxt_empty = 1'b0, k_done = 1'b0;
    logic [7:0] up_data = '0;
    logic up_ready, col_empty, k_start, core_valid, core_wlast;
    logic [7:0] core_data;
    logic [VPW-1:0] core_vpos;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int gi = 0, nks = 0, viol = 0;
    logic clr = 1'b1, ne_q = 1'b0;
    logic [7:0] gd [0:1023];
    logic [VPW-1:0] gv [0:1023];
    logic gl [0:1023];

    always #2.5 clk = ~clk;

    spk_feature_buf #(.ROWS(ROWS), .CH_BYTES(CHB)) i_spk_feature_buf (
        .clk(clk), .rst(rst), .up_valid(up_valid), .up_data(up_data),
        .up_ready(up_ready), .col_empty(col_empty), .nxt_empty(nxt_empty),
        .k_start(k_start), .k_done(k_done), .core_valid(core_valid),
        .core_data(core_data), .core_vpos(core_vpos), .core_wlast(core_wlast)
    );

    always @(posedge clk) ne_q <= nxt_empty;

    always @(negedge clk) begin
        if (clr) begin
            gi = 0; nks = 0; viol = 0;
        end else begin
            if (core_valid && gi < 1024) begin
                gd[gi] = core_data; gv[gi] = core_vpos; gl[gi] = core_wlast; gi++;
            end
            if (k_start) begin
                nks++;
                if (!ne_q) viol++;
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            summary();
        end
    end

    function automatic logic [7:0] col_byte(int col, int row, int b);
        return 8'(col * 37 + row * 11 + b * 5 + 3);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        clr = 1'b1; rst = 1'b1; nxt_empty = 1'b0; up_valid = 1'b0; k_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0; clr = 1'b0;
    endtask

    task automatic send_cols(int first, int n, int gap);
        for (int c = first; c < first + n; c++)
            for (int r = 0; r < ROWS; r++)
                for (int b = 0; b < CHB; b++) begin
                    up_data = col_byte(c, r, b); up_valid = 1'b1;
                    while (!up_ready) @(negedge clk);
                    @(negedge clk);
                    up_valid = 1'b0;
                    repeat (gap) @(negedge clk);
                end
    endtask

    task automatic pulse_done();
        k_done = 1'b1; @(negedge clk); k_done = 1'b0;
    endtask

    task automatic drive_convs(int nconv, int dly, int early);
        for (int k = 0; k < nconv; k++) begin
            while (!k_start) @(negedge clk);
            if (early != 0) begin
                while (gi < k * BPC + 5) @(negedge clk);
                pulse_done();
            end
            while (gi < (k + 1) * BPC) @(negedge clk);
            repeat (dly) @(negedge clk);
            pulse_done();
        end
    endtask

    task automatic check_conv(int k, int base_col);
        for (int v = 0; v < NVP; v++)
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++)
                    for (int b = 0; b < CHB; b++) begin
                        int i;
                        logic [31:0] act, exp;
                        i = k * BPC + ((v * 3 + r) * 3 + c) * CHB + b;
                        exp = {22'd0, (r == 2 && c == 2 && b == CHB - 1), VPW'(v),
                               col_byte(base_col + c, v + r, b)};
                        act = {22'd0, gl[i], gv[i], gd[i]};
                        // R2 R5 R6 R7: byte, vpos and window-last of each beat
                        check("R5", act, exp);
                    end
    endtask

    initial begin
        // R1: reset state
        do_reset();
        check("R1", {28'd0, up_ready, col_empty, core_valid, k_start}, 32'hC);

        for (int t = 0; t < NCASE; t++) begin
            do_reset();
            fork
                send_cols(0, TBL[t][0], TBL[t][1]);
                begin repeat (TBL[t][2]) @(negedge clk); nxt_empty = 1'b1; end
                drive_convs(TBL[t][0] - 2, TBL[t][3], TBL[t][4]);
            join
            repeat (20) @(negedge clk);
            // R4 R7: exact number of operations and beats, starts gated by nxt_empty
            check("R4", nks, TBL[t][0] - 2);
            check("R4", viol, 0);
            check("R7", gi, (TBL[t][0] - 2) * BPC);
            for (int k = 0; k < TBL[t][0] - 2; k++) check_conv(k, k);
        end

        // R3 R8: full pipeline with next layer busy
        do_reset();
        send_cols(0, 1, 0);
        check("R2", {31'd0, col_empty}, 0);
        send_cols(1, 3, 0);
        @(negedge clk);
        check("R3", {31'd0, up_ready}, 0);
        repeat (10) @(negedge clk);
        check("R4", nks, 0);
        check("R3", {31'd0, up_ready}, 0);
        nxt_empty = 1'b1;
        while (!k_start) @(negedge clk);
        check("R8", {31'd0, up_ready}, 0);
        while (gi < BPC) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R8", {31'd0, up_ready}, 0);
        pulse_done();
        repeat (3) @(negedge clk);
        check("R3", {30'd0, up_ready, col_empty}, 3);
        while (gi < 2 * BPC) @(negedge clk);
        pulse_done();
        check_conv(0, 0);
        check_conv(1, 1);
        check("R4", nks, 2);

        summary();
    end

endmodule